// File: doc/BRIEF.md
# Multiplexed Bus Initiator Engine

This block is the bus-master side of a synchronous bus. Address and data share one 32-bit set of lines, and every control strobe is active low. A local client hands over one request at a time: a 4-bit command, a 64-bit start address, a word count and a byte-enable mask. The engine then asks the arbiter for the bus. Once it holds a grant and the bus is quiet, it runs one address phase, or two when the upper address half is non-zero. After that it runs data phases, each paced by its own ready strobe and the target's ready strobe.

Write words come from a local stream, and the engine pulls one word per completed data phase. Read words return one cycle after each completed data phase. When the transaction ends, a one-cycle done pulse reports one of four outcomes: normal completion, target retry, target disconnect, or master abort when no target claims the cycle. It also reports the word count still outstanding and the address to resume from. A retried or disconnected request is finished from the local side's point of view. To continue, the client issues a new request, and the engine arbitrates for the bus again.

Top module: `mux_bus_initiator`

## Requirements
- R1: In the first address phase `cyc_n_o` is low, `ab_oe` is high, `ab_o` carries address bits 31:0 and `cmd_be_n_o` carries the 4-bit command. The bench uses these commands: 0110 memory read, 0111 memory write, 1100 memory read multiple, 0011 I/O write. Bit 0 of the command set to 1 means write.
- R2: When address bits 63:32 are non-zero, the first address phase carries command code 1101 with the low address half. A second address phase follows with the real command on `cmd_be_n_o` and address bits 63:32 on `ab_o`.
- R3: A request waits with `bus_req_n` low. The address phase starts only after an edge where `bus_grant_n` is low and both `obs_cyc_n` and `obs_mrdy_n` are high. While the grant is withheld or the bus is busy, `cyc_n_o` stays high.
- R4: A word moves only on an edge where `mrdy_n_o`, `tgt_ready_n` and `tgt_claim_n` are all low. `mrdy_n_o` stays high while `lcl_ready` is low, unless the final phase is already committed. During data phases `cmd_be_n_o` is the bitwise inverse of the request's byte enables.
- R5: A burst moves consecutive words, and the address steps by 4 bytes per word. Write words come from `wr_data`, with `wr_pull` high in each cycle whose edge consumes a word. Each read word appears on `rd_data` with `rd_valid` high in the cycle after its transfer edge.
- R6: `cyc_n_o` goes high only in the final data phase, and only together with `mrdy_n_o` low. From then on `mrdy_n_o` stays low until that final word moves or the target halts.
- R7: On a read the engine stops driving the lines (`ab_oe` low) in the cycle after the last address phase, and keeps them undriven in all read data phases.
- R8: I/O commands (0010 and 0011) run exactly one data phase, whatever the requested count. Counts are 1 or more.
- R9: When `tgt_halt_n` is low before any word has moved, the result is status 1 (retry), the remaining count equals the requested count and the resume address equals the start address. In the done cycle `cyc_n_o`, `mrdy_n_o` and `bus_req_n` are all high.
- R10: When `tgt_halt_n` is low after one or more words have moved, the result is status 2 (disconnect), with the count still outstanding and the address of the next unmoved word.
- R11: If `tgt_claim_n` stays high through the 4 cycles after the last address phase, the transaction ends with status 3 (master abort). A claim arriving in the 4th cycle is still accepted.
- R12: On normal completion `done_valid` pulses for one cycle, in the cycle after the final transfer, with status 0, remaining count 0 and the address following the last word. `busy` is high from acceptance until the done cycle ends, and is low after reset.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | 64 | Byte start address |
| req_count | input | 8 | Number of words (1 or more) |
| req_be | input | 4 | Active-high byte enables for every data phase |
| busy | output | 1 | A request is in progress |
| wr_data | input | 32 | Current write word from the local stream |
| wr_pull | output | 1 | The current write word is consumed at this edge |
| lcl_ready | input | 1 | Local side ready to source or sink a word |
| rd_valid | output | 1 | A read word is on `rd_data` |
| rd_data | output | 32 | Read word |
| done_valid | output | 1 | One-cycle end-of-transaction pulse |
| done_status | output | 2 | 0 done, 1 retry, 2 disconnect, 3 master abort |
| done_remaining | output | 8 | Words not moved |
| done_next_addr | output | 64 | Address to resume from |
| bus_req_n | output | 1 | Bus request to the arbiter, active low |
| bus_grant_n | input | 1 | Bus grant, active low |
| obs_cyc_n | input | 1 | Observed shared cycle strobe from other masters |
| obs_mrdy_n | input | 1 | Observed shared master-ready strobe from other masters |
| cyc_n_o | output | 1 | Cycle strobe, active low |
| mrdy_n_o | output | 1 | Master ready strobe, active low |
| ab_o | output | 32 | Address/data lines driven by the engine |
| ab_oe | output | 1 | Drive enable for `ab_o` |
| ab_i | input | 32 | Address/data lines as seen on the bus |
| cmd_be_n_o | output | 4 | Command in address phases, inverted byte enables in data phases |
| tgt_ready_n | input | 1 | Target ready, active low |
| tgt_halt_n | input | 1 | Target stop request, active low |
| tgt_claim_n | input | 1 | Target claims the cycle, active low |

## Verification
The embedded properties check the per-cycle rules on every clock. The final-phase hold on the strobes, the link between a granted edge and the cycle strobe falling, and read capture only while the lines are released are all covered there. So are a master abort only after an unclaimed cycle, a retry leaving the count untouched, and no count underflow. Only the bench scenarios can show the end-to-end results. These include the exact address and command carried in one or two address phases, word order and data through bursts with wait states from both sides, and the single-phase I/O rule. They also include the returned remaining count and resume address after a disconnect, and the timeout boundary between a late claim and an abort.

// File: rtl/mbi_pkg.sv
// Shared types and command decoding for the multiplexed bus initiator.
// Assumes a 4-bit command field whose bit 0 marks a write.
package mbi_pkg;

    localparam int ADDR_W = 64;
    localparam logic [3:0] CMD_DUAL_ADDR = 4'b1101;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ARB    = 3'd1,
        S_ADR_LO = 3'd2,
        S_ADR_HI = 3'd3,
        S_TURN   = 3'd4,
        S_DATA   = 3'd5,
        S_REL    = 3'd6
    } mbi_state_e;

    typedef enum logic [1:0] {
        MBI_OK     = 2'd0,
        MBI_RETRY  = 2'd1,
        MBI_DISC   = 2'd2,
        MBI_MABORT = 2'd3
    } mbi_status_e;

    // Commands with bit 0 set move data from master to target.
    function automatic logic cmd_writes(input logic [3:0] c);
        return c[0];
    endfunction

    // I/O commands (0010, 0011) always use a single data phase.
    function automatic logic cmd_single(input logic [3:0] c);
        return (c[3:1] == 3'b001);
    endfunction

endpackage

// File: rtl/mbi_xfer_track.sv
// Address and word-count tracker.
// Loads the start address and count when a request is accepted, then steps
// the address by STEP bytes and decrements the count on each moved word.
// Assumes adv is never raised when the count is already zero.
module mbi_xfer_track #(
    parameter int CNT_W  = 8,
    parameter int STEP   = 4,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic              adv,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  remaining,
    output logic              last,
    output logic              moved_any
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
    localparam logic [CNT_W-1:0]  ONE_C  = CNT_W'(1);

    // Hold the resume point: next address, words left, whether any moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remaining <= '0;
            moved_any <= 1'b0;
        end else if (load) begin
            cur_addr  <= ld_addr;
            remaining <= ld_count;
            moved_any <= 1'b0;
        end else if (adv) begin
            cur_addr  <= cur_addr + STEP_V;
            remaining <= remaining - ONE_C;
            moved_any <= 1'b1;
        end
    end

    // Flag the final word so the sequencer can end the cycle strobe.
    always_comb last = (remaining == ONE_C);

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (remaining != '0));

endmodule

// File: rtl/mbi_claim_timer.sv
// Claim watchdog for the master-abort decision.
// Cleared during the address phases, it counts the cycles that follow them.
// It raises expired in the TMO-th such cycle if no claim has been seen and
// the claim input is still high in that cycle.
module mbi_claim_timer #(
    parameter int TMO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    input  logic claim_n,
    output logic claimed,
    output logic expired
);

    localparam int CW = $clog2(TMO + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TMO - 1);

    logic [CW-1:0] cnt;

    // Count post-address cycles and remember whether a target claimed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            claimed <= 1'b0;
        end else if (arm) begin
            cnt     <= '0;
            claimed <= 1'b0;
        end else if (run) begin
            if (!claim_n) claimed <= 1'b1;
            if (cnt != LIMIT) cnt <= cnt + CW'(1);
        end
    end

    // Time out in the last allowed cycle when still unclaimed.
    always_comb expired = run && !claimed && claim_n && (cnt == LIMIT);

    assert_claim_from_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(claimed) |-> $past(!claim_n));

endmodule

// File: rtl/mbi_seq.sv
// Bus sequencer for the initiator.
// It walks from arbitration through the address phases and an optional read
// turnaround into the data phases, then spends one release cycle.
// Assumes the target stop input stays asserted until the cycle has ended.
module mbi_seq
    import mbi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        is_write,
    input  logic        dual,
    input  logic        grant_n,
    input  logic        obs_cyc_n,
    input  logic        obs_mrdy_n,
    input  logic        lcl_ready,
    input  logic        tgt_ready_n,
    input  logic        tgt_halt_n,
    input  logic        tgt_claim_n,
    input  logic        last,
    input  logic        moved_any,
    input  logic        expired,
    output mbi_state_e  state,
    output mbi_status_e status,
    output logic        xfer,
    output logic        cyc_n,
    output logic        mrdy_n,
    output logic        req_n
);

    mbi_state_e  nxt;
    mbi_status_e status_d;
    logic        last_commit;

    // Drive the master strobes from the state and the final-phase latch.
    always_comb begin
        mrdy_n = !((state == S_DATA) && (lcl_ready || last_commit));
        req_n  = (state != S_ARB);
        unique case (state)
            S_ADR_LO, S_ADR_HI, S_TURN: cyc_n = 1'b0;
            S_DATA:                     cyc_n = last && !mrdy_n;
            default:                    cyc_n = 1'b1;
        endcase
        xfer = (state == S_DATA) && !mrdy_n && !tgt_ready_n && !tgt_claim_n;
    end

    // Choose the next state and the completion code of this transaction.
    always_comb begin
        nxt      = state;
        status_d = status;
        unique case (state)
            S_IDLE:   if (req_valid) nxt = S_ARB;
            S_ARB:    if (!grant_n && obs_cyc_n && obs_mrdy_n) nxt = S_ADR_LO;
            S_ADR_LO: nxt = dual ? S_ADR_HI : (is_write ? S_DATA : S_TURN);
            S_ADR_HI: nxt = is_write ? S_DATA : S_TURN;
            S_TURN:   nxt = S_DATA;
            S_DATA: begin
                if (xfer && last) begin
                    nxt      = S_REL;
                    status_d = MBI_OK;
                end else if (!tgt_halt_n) begin
                    nxt      = S_REL;
                    status_d = (moved_any || xfer) ? MBI_DISC : MBI_RETRY;
                end else if (expired) begin
                    nxt      = S_REL;
                    status_d = MBI_MABORT;
                end
            end
            S_REL:    nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // Register state and status; latch the committed final phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            status      <= MBI_OK;
            last_commit <= 1'b0;
        end else begin
            state  <= nxt;
            status <= status_d;
            if (state != S_DATA || nxt != S_DATA) last_commit <= 1'b0;
            else if (last && !mrdy_n)             last_commit <= 1'b1;
        end
    end

    assert_last_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && cyc_n && !xfer && tgt_halt_n && !expired)
            |=> (!mrdy_n && cyc_n));

    assert_cyc_needs_mrdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && cyc_n) |-> !mrdy_n);

endmodule

// File: rtl/mux_bus_initiator.sv
// Top of the multiplexed bus initiator.
// Latches one local request, sequences it on the shared address/data lines,
// streams write words in and read words out, and reports the outcome with a
// resume point. Assumes wr_data holds the next write word whenever the
// master ready strobe is low in a write data phase.
module mux_bus_initiator
    import mbi_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 8,
    parameter int CLAIM_TO = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [3:0]          req_cmd,
    input  logic [63:0]         req_addr,
    input  logic [CNT_W-1:0]    req_count,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                busy,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                wr_pull,
    input  logic                lcl_ready,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                done_valid,
    output logic [1:0]          done_status,
    output logic [CNT_W-1:0]    done_remaining,
    output logic [63:0]         done_next_addr,
    output logic                bus_req_n,
    input  logic                bus_grant_n,
    input  logic                obs_cyc_n,
    input  logic                obs_mrdy_n,
    output logic                cyc_n_o,
    output logic                mrdy_n_o,
    output logic [DATA_W-1:0]   ab_o,
    output logic                ab_oe,
    input  logic [DATA_W-1:0]   ab_i,
    output logic [DATA_W/8-1:0] cmd_be_n_o,
    input  logic                tgt_ready_n,
    input  logic                tgt_halt_n,
    input  logic                tgt_claim_n
);

    localparam int BE_W = DATA_W / 8;
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    mbi_state_e       state;
    mbi_status_e      status;
    logic             xfer;
    logic             accept;
    logic [3:0]       cmd_q;
    logic [BE_W-1:0]  be_q;
    logic             wr_q;
    logic             dual_q;
    logic [CNT_W-1:0] start_cnt_q;
    logic [63:0]      cur_addr;
    logic [CNT_W-1:0] remaining;
    logic             last;
    logic             moved_any;
    logic             claimed;
    logic             expired;
    logic             rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;

    always_comb accept = (state == S_IDLE) && req_valid;

    // Capture the request attributes that stay fixed for the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            be_q        <= '0;
            wr_q        <= 1'b0;
            dual_q      <= 1'b0;
            start_cnt_q <= '0;
        end else if (accept) begin
            cmd_q       <= req_cmd;
            be_q        <= req_be;
            wr_q        <= cmd_writes(req_cmd);
            dual_q      <= (req_addr[63:32] != 32'h0);
            start_cnt_q <= cmd_single(req_cmd) ? ONE_C : req_count;
        end
    end

    mbi_xfer_track #(
        .CNT_W (CNT_W),
        .STEP  (BE_W),
        .ADDR_W(64)
    ) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .ld_addr  (req_addr),
        .ld_count (cmd_single(req_cmd) ? ONE_C : req_count),
        .adv      (xfer),
        .cur_addr (cur_addr),
        .remaining(remaining),
        .last     (last),
        .moved_any(moved_any)
    );

    mbi_claim_timer #(
        .TMO(CLAIM_TO)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (state == S_ADR_LO || state == S_ADR_HI),
        .run    (state == S_TURN || state == S_DATA),
        .claim_n(tgt_claim_n),
        .claimed(claimed),
        .expired(expired)
    );

    mbi_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .is_write   (wr_q),
        .dual       (dual_q),
        .grant_n    (bus_grant_n),
        .obs_cyc_n  (obs_cyc_n),
        .obs_mrdy_n (obs_mrdy_n),
        .lcl_ready  (lcl_ready),
        .tgt_ready_n(tgt_ready_n),
        .tgt_halt_n (tgt_halt_n),
        .tgt_claim_n(tgt_claim_n),
        .last       (last),
        .moved_any  (moved_any),
        .expired    (expired),
        .state      (state),
        .status     (status),
        .xfer       (xfer),
        .cyc_n      (cyc_n_o),
        .mrdy_n     (mrdy_n_o),
        .req_n      (bus_req_n)
    );

    // Select what the engine drives on the shared lines in each phase.
    always_comb begin
        ab_o       = '0;
        ab_oe      = 1'b0;
        cmd_be_n_o = '1;
        unique case (state)
            S_ADR_LO: begin
                ab_o       = cur_addr[31:0];
                ab_oe      = 1'b1;
                cmd_be_n_o = dual_q ? CMD_DUAL_ADDR : cmd_q;
            end
            S_ADR_HI: begin
                ab_o       = cur_addr[63:32];
                ab_oe      = 1'b1;
                cmd_be_n_o = cmd_q;
            end
            S_TURN: cmd_be_n_o = ~be_q;
            S_DATA: begin
                ab_o       = wr_q ? wr_data : '0;
                ab_oe      = wr_q;
                cmd_be_n_o = ~be_q;
            end
            default: ;
        endcase
    end

    // Register each read word captured at a completed data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= xfer && !wr_q;
            if (xfer && !wr_q) rd_data_q <= ab_i;
        end
    end

    // Present local-side results.
    always_comb begin
        wr_pull        = xfer && wr_q;
        rd_valid       = rd_valid_q;
        rd_data        = rd_data_q;
        busy           = (state != S_IDLE);
        done_valid     = (state == S_REL);
        done_status    = status;
        done_remaining = remaining;
        done_next_addr = cur_addr;
    end

    assert_start_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cyc_n_o) |-> $past(!bus_grant_n && obs_cyc_n && obs_mrdy_n));

    assert_read_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_q |-> $past(!ab_oe));

    assert_read_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_q |-> $past(!mrdy_n_o && !tgt_ready_n && !tgt_claim_n));

    assert_retry_keeps_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_status == MBI_RETRY) |-> (done_remaining == start_cnt_q));

    assert_abort_unclaimed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_status == MBI_MABORT) |-> ($past(tgt_claim_n) && !claimed));

    assert_done_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (cyc_n_o && mrdy_n_o && bus_req_n && !ab_oe));

endmodule

// File: tb/mux_bus_initiator_tb_top.sv
// Scoreboard bench. Driver tasks queue the expected write and read words;
// a per-cycle target model pops write words as they cross the bus and
// compares read words as they return on the local side.
module mux_bus_initiator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_cmd = '0;
    logic [63:0] req_addr = '0;
    logic [7:0]  req_count = '0;
    logic [3:0]  req_be = '0;
    logic        busy;
    logic [31:0] wr_data = '0;
    logic        wr_pull;
    logic        lcl_ready = 1'b1;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        done_valid;
    logic [1:0]  done_status;
    logic [7:0]  done_remaining;
    logic [63:0] done_next_addr;
    logic        bus_req_n;
    logic        bus_grant_n = 1'b0;
    logic        obs_cyc_n = 1'b1;
    logic        obs_mrdy_n = 1'b1;
    logic        cyc_n_o;
    logic        mrdy_n_o;
    logic [31:0] ab_o;
    logic        ab_oe;
    logic [31:0] ab_i = '0;
    logic [3:0]  cmd_be_n_o;
    logic        tgt_ready_n = 1'b1;
    logic        tgt_halt_n = 1'b1;
    logic        tgt_claim_n = 1'b1;

    always #4 clk = ~clk;

    mux_bus_initiator dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_count(req_count), .req_be(req_be), .busy(busy),
        .wr_data(wr_data), .wr_pull(wr_pull), .lcl_ready(lcl_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .done_valid(done_valid),
        .done_status(done_status), .done_remaining(done_remaining),
        .done_next_addr(done_next_addr), .bus_req_n(bus_req_n),
        .bus_grant_n(bus_grant_n), .obs_cyc_n(obs_cyc_n), .obs_mrdy_n(obs_mrdy_n),
        .cyc_n_o(cyc_n_o), .mrdy_n_o(mrdy_n_o), .ab_o(ab_o), .ab_oe(ab_oe),
        .ab_i(ab_i), .cmd_be_n_o(cmd_be_n_o), .tgt_ready_n(tgt_ready_n),
        .tgt_halt_n(tgt_halt_n), .tgt_claim_n(tgt_claim_n)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard queues and target configuration.
    logic [31:0] exp_wr_q[$];
    logic [31:0] exp_rd_q[$];
    logic [31:0] mem[64];
    int  sel_delay = 1;
    int  stop_after = -1;
    int  wait_pat = 0;
    int  rdy_pat = 0;
    bit  gnt_block = 0;
    int  busy_left = 0;
    logic [31:0] wbase = '0;
    int  wr_idx = 0;
    logic [3:0] exp_be = '0;

    // Target-side observations.
    bit  t_active = 0;
    bit  t_dac = 0;
    bit  t_in_hi = 0;
    int  t_cnt = 0;
    int  t_words = 0;
    logic [31:0] cap_lo = '0;
    logic [31:0] cap_hi = '0;
    logic [3:0]  cap_first = '0;
    logic [3:0]  t_cmd = '0;
    bit  turn_oe = 0;
    bit  last_cyc_n = 0;
    bit  early_end = 0;
    bit  rd_oe_seen = 0;
    bit  prev_cyc_n = 1;
    int  cyc = 0;

    bit  done_seen = 0;
    logic [1:0]  got_status = '0;
    logic [7:0]  got_rem = '0;
    logic [63:0] got_next = '0;
    int  exp_n = 0;

    // Per-cycle local drive, target model and monitor.
    always begin
        @(negedge clk);
        cyc++;
        lcl_ready   = (rdy_pat == 0) ? 1'b1 : cyc[0];
        wr_data     = wbase + 32'(wr_idx);
        bus_grant_n = gnt_block;
        obs_cyc_n   = (busy_left > 0) ? 1'b0 : 1'b1;
        if (busy_left > 0) busy_left--;
        #1;
        if (!rst_n) begin
            t_active = 0;
        end else if (t_active && cyc_n_o && mrdy_n_o) begin
            t_active = 0;
            tgt_claim_n = 1; tgt_ready_n = 1; tgt_halt_n = 1;
        end else if (!t_active && !cyc_n_o && prev_cyc_n) begin
            t_active = 1; t_cnt = 0; t_words = 0;
            cap_lo = ab_o; cap_first = cmd_be_n_o; t_cmd = cmd_be_n_o;
            t_dac = (cmd_be_n_o == 4'b1101); t_in_hi = t_dac;
            early_end = 0; rd_oe_seen = 0;
        end else if (t_active && t_in_hi) begin
            cap_hi = ab_o; t_cmd = cmd_be_n_o; t_in_hi = 0;
        end else if (t_active) begin
            logic sel, stp, rdy;
            logic [5:0] idx;
            t_cnt++;
            if (t_cnt == 1) turn_oe = ab_oe;
            sel = (t_cnt >= sel_delay);
            stp = sel && (stop_after >= 0) && (t_words == stop_after);
            rdy = sel && !stp && (wait_pat == 0 || t_cnt[0] == 1'b0);
            tgt_claim_n = !sel; tgt_halt_n = !stp; tgt_ready_n = !rdy;
            idx = 6'((cap_lo >> 2) + 32'(t_words));
            ab_i = mem[idx];
            if (!mrdy_n_o && rdy) begin
                if (!t_cmd[0] && ab_oe) rd_oe_seen = 1;
                if (cyc_n_o && (t_words + 1 < exp_n)) early_end = 1;
                last_cyc_n = cyc_n_o;
                chk(cmd_be_n_o == ~exp_be, "R4 byte enables in data phase",
                    64'(cmd_be_n_o), 64'(~exp_be));
                if (t_cmd[0]) begin
                    if (exp_wr_q.size() == 0) begin
                        chk(0, "R5 unexpected write word", 64'(ab_o), 0);
                    end else begin
                        logic [31:0] e;
                        e = exp_wr_q.pop_front();
                        chk(ab_o == e, "R5 write word order", 64'(ab_o), 64'(e));
                    end
                    mem[idx] = ab_o;
                end
                t_words++;
            end
        end
        prev_cyc_n = cyc_n_o;
        #1;
        if (wr_pull) wr_idx++;
        if (rd_valid) begin
            if (exp_rd_q.size() == 0) begin
                chk(0, "R5 unexpected read word", 64'(rd_data), 0);
            end else begin
                logic [31:0] e;
                e = exp_rd_q.pop_front();
                chk(rd_data == e, "R5 read word order", 64'(rd_data), 64'(e));
            end
        end
        if (done_valid) begin
            done_seen  = 1;
            got_status = done_status;
            got_rem    = done_remaining;
            got_next   = done_next_addr;
            chk(cyc_n_o && mrdy_n_o && bus_req_n, "R9 bus released at done",
                {61'd0, cyc_n_o, mrdy_n_o, bus_req_n}, 64'd7);
        end
    end

    // Driver: queue expectations and raise one request.
    task automatic start_req(input logic [3:0] cmd, input logic [63:0] addr,
                             input int count, input logic [3:0] be, input bit abort);
        int n;
        n = (cmd[3:1] == 3'b001) ? 1 : count;
        if (abort) n = 0;
        if (stop_after >= 0 && stop_after < n) n = stop_after;
        exp_n = n;
        exp_be = be;
        wbase = 32'hA500_0000 + 32'(cyc) * 32'h100;
        wr_idx = 0;
        for (int i = 0; i < n; i++) begin
            if (cmd[0]) exp_wr_q.push_back(wbase + 32'(i));
            else exp_rd_q.push_back(mem[6'((addr[31:0] >> 2) + 32'(i))]);
        end
        done_seen = 0;
        @(posedge clk); #1;
        req_cmd = cmd; req_addr = addr; req_count = 8'(count); req_be = be;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        wait (done_seen);
        @(negedge clk); #3;
        chk(exp_wr_q.size() == 0 && exp_rd_q.size() == 0, "R5 all queued words seen",
            64'(exp_wr_q.size() + exp_rd_q.size()), 0);
    endtask

    task automatic chk_done(input string tag, input logic [1:0] st, input int rem,
                            input logic [63:0] nxt);
        chk(got_status == st, {tag, " status"}, 64'(got_status), 64'(st));
        chk(got_rem == 8'(rem), {tag, " remaining"}, 64'(got_rem), 64'(rem));
        chk(got_next == nxt, {tag, " resume address"}, got_next, nxt);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk); #3;
        // R12, R3: quiet after reset
        chk(!busy && bus_req_n && cyc_n_o && mrdy_n_o && !ab_oe && !done_valid,
            "R12 reset state", {58'd0, busy, bus_req_n, cyc_n_o, mrdy_n_o, ab_oe, done_valid},
            64'b011100);

        // R1 R5 R6 R12: plain write burst
        start_req(4'b0111, 64'h40, 4, 4'hF, 0); wait_done();
        chk(cap_lo == 32'h40 && cap_first == 4'b0111, "R1 address phase",
            {28'd0, cap_first, cap_lo}, {28'd0, 4'b0111, 32'h40});
        chk(last_cyc_n && !early_end, "R6 cycle strobe ends on final phase only",
            {62'd0, last_cyc_n, early_end}, 64'b10);
        chk_done("R12 write", 2'd0, 0, 64'h50);

        // R4 R7: read burst with target and local wait states
        wait_pat = 1; rdy_pat = 1;
        start_req(4'b0110, 64'h40, 4, 4'h3, 0); wait_done();
        chk(!turn_oe && !rd_oe_seen, "R7 lines released on read",
            {62'd0, turn_oe, rd_oe_seen}, 0);
        chk(last_cyc_n && !early_end, "R6 final phase with waits",
            {62'd0, last_cyc_n, early_end}, 64'b10);
        chk_done("R12 read", 2'd0, 0, 64'h50);

        // R4: write paced by the local ready input, partial byte enables
        wait_pat = 0;
        start_req(4'b0111, 64'h80, 3, 4'h5, 0); wait_done();
        chk_done("R4 paced write", 2'd0, 0, 64'h8C);
        rdy_pat = 0;

        // R2: dual address read
        start_req(4'b1100, 64'h0000_0001_0000_0100, 2, 4'hF, 0); wait_done();
        chk(cap_first == 4'b1101 && cap_lo == 32'h100, "R2 first address phase",
            {28'd0, cap_first, cap_lo}, {28'd0, 4'b1101, 32'h100});
        chk(t_cmd == 4'b1100 && cap_hi == 32'h1, "R2 second address phase",
            {28'd0, t_cmd, cap_hi}, {28'd0, 4'b1100, 32'h1});
        chk_done("R2 dual read", 2'd0, 0, 64'h0000_0001_0000_0108);

        // R8: I/O write ignores the count
        start_req(4'b0011, 64'h10, 5, 4'h1, 0); wait_done();
        chk(t_words == 1, "R8 single I/O data phase", 64'(t_words), 1);
        chk_done("R8 io", 2'd0, 0, 64'h14);

        // R3: grant withheld
        gnt_block = 1;
        start_req(4'b0111, 64'h0, 1, 4'hF, 0);
        repeat (5) @(negedge clk);
        #3;
        chk(cyc_n_o && !bus_req_n, "R3 wait for grant",
            {62'd0, cyc_n_o, bus_req_n}, 64'b10);
        gnt_block = 0;
        wait_done();
        chk_done("R3 granted", 2'd0, 0, 64'h4);

        // R3: bus busy with another master
        busy_left = 6;
        start_req(4'b0111, 64'h4, 1, 4'hF, 0);
        repeat (3) @(negedge clk);
        #3;
        chk(cyc_n_o && !bus_req_n, "R3 wait for idle bus",
            {62'd0, cyc_n_o, bus_req_n}, 64'b10);
        wait_done();
        chk_done("R3 after idle", 2'd0, 0, 64'h8);

        // R9: retry, then the local side issues the request again
        stop_after = 0;
        start_req(4'b0111, 64'h60, 3, 4'hF, 0); wait_done();
        chk_done("R9 retry", 2'd1, 3, 64'h60);
        stop_after = -1;
        start_req(4'b0111, 64'h60, 3, 4'hF, 0); wait_done();
        chk_done("R9 reissued", 2'd0, 0, 64'h6C);

        // R10: disconnect after two of five words
        stop_after = 2;
        start_req(4'b0111, 64'h20, 5, 4'hF, 0); wait_done();
        chk_done("R10 disconnect", 2'd2, 3, 64'h28);
        stop_after = -1;

        // R11: claim in the 4th cycle is accepted
        sel_delay = 4;
        start_req(4'b0111, 64'h30, 2, 4'hF, 0); wait_done();
        chk_done("R11 late claim", 2'd0, 0, 64'h38);

        // R11: no claim in 4 cycles aborts
        sel_delay = 5;
        start_req(4'b0111, 64'h30, 2, 4'hF, 1); wait_done();
        chk_done("R11 master abort", 2'd3, 2, 64'h30);
        sel_delay = 1;

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule